// File: doc/BRIEF.md
# Load-Use and Branch Stall Cycle Accountant

This block keeps the cycle books for an in-order core that can issue two instructions side by side. Each clock it may receive one issued instruction. The instruction comes with two source register codes, a load flag with its destination register, a branch flag with its taken outcome, a base cycle count, and flags that mark the first and the last instruction of an issue group. A group is either a single instruction or a parallel pair.

The block remembers which general registers were just written by a load. An instruction that reads one of them is charged a load-use penalty. A taken branch is charged a redirect penalty. The per-instruction totals feed a running cycle count. A parallel pair costs only as much as the slower of its two members, while the stall tallies and the branch outcome counts accumulate for every instruction on their own.

Top module: `stall_tally`

## Requirements
- R1: While `rst_n` is low, the clock edge clears every counter output and `load_mask` to zero.
- R2: Bit i of `load_mask` stands for general register i. Each source whose code is below 16 and whose bit is set in `load_mask` adds 2 cycles to that instruction's load stall, so two hitting sources add 4. Source codes 16 to 31 mean "no register" and never stall.
- R3: When `in_is_load` is set, the instruction marks its destination for the following instructions only, never for itself. After each instruction, `load_mask` holds the destinations loaded so far within the current group. A group-first instruction without a load therefore leaves `load_mask` at zero.
- R4: A branch with `in_taken` set adds 2 cycles to `branch_stall_cycles` and to the instruction total, and increments `taken_count`.
- R5: A branch with `in_taken` clear increments only `untaken_count`. A non-branch changes neither branch count.
- R6: An instruction's total is `in_base` plus its load stall plus its branch stall. A single-instruction group (first and last both set) adds that total to `total_cycles`.
- R7: In a pair, the non-last instruction adds nothing to `total_cycles`. The last instruction adds the larger of its own total and the earlier member's total.
- R8: Load-stall and branch-stall cycles of every instruction, including both members of a pair, accumulate in full in their own counters.
- R9: A cycle with `in_valid` low changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_first | input | 1 | Instruction opens an issue group |
| in_last | input | 1 | Instruction closes an issue group |
| in_src_a | input | 5 | First source register code (16 to 31 = none) |
| in_src_b | input | 5 | Second source register code (16 to 31 = none) |
| in_is_load | input | 1 | Instruction is a load |
| in_dst | input | 4 | Load destination register |
| in_is_branch | input | 1 | Instruction is a branch |
| in_taken | input | 1 | Branch outcome is taken |
| in_base | input | 8 | Base cycle count of the instruction |
| total_cycles | output | 32 | Accumulated group cycles |
| load_stall_cycles | output | 32 | Accumulated load-use stall cycles |
| branch_stall_cycles | output | 32 | Accumulated taken-branch stall cycles |
| taken_count | output | 32 | Taken branches seen |
| untaken_count | output | 32 | Not-taken branches seen |
| load_mask | output | 16 | Registers currently charged as load-use hazards |

## Verification
Every output is a register. The effect of an instruction presented in one cycle appears one rising edge later. An instruction that reads a loaded register shows its stall one edge after its own presentation, which is two edges after the load's. The driver applies each instruction on a falling edge and queues the counter and mask values due after the next rising edge. The monitor pops and compares them 5 ns after that edge, so every comparison lands in the cycle the result becomes due. Idle cycles queue unchanged values, so any stray update between instructions is caught at the edge where it happens.

// File: rtl/st_pkg.sv
package st_pkg;
    localparam int unsigned LOAD_USE_PENALTY = 2;
    localparam int unsigned REDIRECT_PENALTY = 2;
    localparam int unsigned NUM_SOURCES      = 2;
endpackage

// File: rtl/st_src_probe.sv
module st_src_probe #(
    parameter int NREG  = 16,
    parameter int SRC_W = 5
) (
    input  logic [SRC_W-1:0] src,
    input  logic [NREG-1:0]  busy,
    output logic             hit
);
    localparam int IDX_W = $clog2(NREG);

    logic in_range;
    assign in_range = ({1'b0, src} < (SRC_W+1)'(NREG));
    assign hit      = in_range && busy[src[IDX_W-1:0]];
endmodule

// File: rtl/st_pair_max.sv
module st_pair_max #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] own,
    input  logic [CNT_W-1:0] prior,
    output logic [CNT_W-1:0] charge
);
    assign charge = (own > prior) ? own : prior;
endmodule

// File: rtl/stall_tally.sv
module stall_tally
    import st_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int SRC_W  = 5,
    parameter int DST_W  = 4,
    parameter int BASE_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [SRC_W-1:0]  in_src_a,
    input  logic [SRC_W-1:0]  in_src_b,
    input  logic              in_is_load,
    input  logic [DST_W-1:0]  in_dst,
    input  logic              in_is_branch,
    input  logic              in_taken,
    input  logic [BASE_W-1:0] in_base,
    output logic [CNT_W-1:0]  total_cycles,
    output logic [CNT_W-1:0]  load_stall_cycles,
    output logic [CNT_W-1:0]  branch_stall_cycles,
    output logic [CNT_W-1:0]  taken_count,
    output logic [CNT_W-1:0]  untaken_count,
    output logic [NREG-1:0]   load_mask
);
    localparam int NSRC = NUM_SOURCES;

    typedef struct packed {
        logic [NREG-1:0]  act;
        logic [NREG-1:0]  pend;
        logic [CNT_W-1:0] run_max;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] lstall;
        logic [CNT_W-1:0] bstall;
        logic [CNT_W-1:0] taken;
        logic [CNT_W-1:0] untaken;
    } tally_t;

    tally_t tally_d, tally_q;

    logic [SRC_W-1:0] srcs [NSRC];
    logic [NSRC-1:0]  hit;
    logic [CNT_W-1:0] ld_pen, br_pen, ins_total, prior_max, charge;

    assign srcs[0] = in_src_a;
    assign srcs[1] = in_src_b;

    for (genvar g = 0; g < NSRC; g++) begin : g_probe
        st_src_probe #(.NREG(NREG), .SRC_W(SRC_W)) u_probe (
            .src  (srcs[g]),
            .busy (tally_q.act),
            .hit  (hit[g])
        );
    end

    assign ld_pen    = CNT_W'(LOAD_USE_PENALTY) * CNT_W'($countones(hit));
    assign br_pen    = (in_is_branch && in_taken) ? CNT_W'(REDIRECT_PENALTY) : '0;
    assign ins_total = CNT_W'(in_base) + ld_pen + br_pen;
    assign prior_max = in_first ? '0 : tally_q.run_max;

    st_pair_max #(.CNT_W(CNT_W)) u_merge (
        .own    (ins_total),
        .prior  (prior_max),
        .charge (charge)
    );

    always_comb begin
        logic [NREG-1:0] pend_next;
        tally_d   = tally_q;
        pend_next = in_first ? '0 : tally_q.pend;
        if (in_valid) begin
            if (in_is_load) begin
                pend_next[in_dst] = 1'b1;
            end
            tally_d.pend   = pend_next;
            tally_d.act    = pend_next;
            tally_d.lstall = tally_q.lstall + ld_pen;
            tally_d.bstall = tally_q.bstall + br_pen;
            if (in_last) begin
                tally_d.total   = tally_q.total + charge;
                tally_d.run_max = '0;
            end else begin
                tally_d.run_max = ins_total;
            end
            if (in_is_branch) begin
                if (in_taken) begin
                    tally_d.taken = tally_q.taken + 1'b1;
                end else begin
                    tally_d.untaken = tally_q.untaken + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tally_q <= '0;
        end else begin
            tally_q <= tally_d;
        end
    end

    assign total_cycles        = tally_q.total;
    assign load_stall_cycles   = tally_q.lstall;
    assign branch_stall_cycles = tally_q.bstall;
    assign taken_count         = tally_q.taken;
    assign untaken_count       = tally_q.untaken;
    assign load_mask           = tally_q.act;
endmodule

// File: rtl/st_checker.sv
module st_checker #(
    parameter int NREG  = 16,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_first,
    input logic             in_last,
    input logic             in_is_load,
    input logic             in_is_branch,
    input logic             in_taken,
    input logic [CNT_W-1:0] total_cycles,
    input logic [CNT_W-1:0] load_stall_cycles,
    input logic [CNT_W-1:0] branch_stall_cycles,
    input logic [CNT_W-1:0] taken_count,
    input logic [CNT_W-1:0] untaken_count,
    input logic [NREG-1:0]  load_mask
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (total_cycles == '0 && load_mask == '0 &&
                    taken_count == '0 && untaken_count == '0));

    assert_stall_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((load_stall_cycles - $past(load_stall_cycles)) == CNT_W'(0) ||
                      (load_stall_cycles - $past(load_stall_cycles)) == CNT_W'(2) ||
                      (load_stall_cycles - $past(load_stall_cycles)) == CNT_W'(4)));

    assert_fresh_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_first && !in_is_load) |=> (load_mask == '0));

    assert_taken_charge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_branch && in_taken) |=>
            (branch_stall_cycles == $past(branch_stall_cycles) + CNT_W'(2) &&
             taken_count == $past(taken_count) + CNT_W'(1)));

    assert_untaken_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_is_branch && !in_taken) |=>
            ($stable(branch_stall_cycles) && $stable(taken_count) &&
             untaken_count == $past(untaken_count) + CNT_W'(1)));

    assert_pair_defer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_last) |=> $stable(total_cycles));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(total_cycles) && $stable(load_stall_cycles) &&
                       $stable(branch_stall_cycles) && $stable(taken_count) &&
                       $stable(untaken_count) && $stable(load_mask)));
endmodule

bind stall_tally st_checker #(.NREG(NREG), .CNT_W(CNT_W)) u_chk (
    .clk                 (clk),
    .rst_n               (rst_n),
    .in_valid            (in_valid),
    .in_first            (in_first),
    .in_last             (in_last),
    .in_is_load          (in_is_load),
    .in_is_branch        (in_is_branch),
    .in_taken            (in_taken),
    .total_cycles        (total_cycles),
    .load_stall_cycles   (load_stall_cycles),
    .branch_stall_cycles (branch_stall_cycles),
    .taken_count         (taken_count),
    .untaken_count       (untaken_count),
    .load_mask           (load_mask)
);

// File: tb/sim_stall_tally.sv
`timescale 1ns/1ps
module sim_stall_tally;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic [4:0]  in_src_a = 5'h10, in_src_b = 5'h10;
    logic        in_is_load = 1'b0, in_is_branch = 1'b0, in_taken = 1'b0;
    logic [3:0]  in_dst = '0;
    logic [7:0]  in_base = '0;
    logic [31:0] total_cycles, load_stall_cycles, branch_stall_cycles, taken_count, untaken_count;
    logic [15:0] load_mask;

    always #10 clk = ~clk;

    stall_tally u0 (.*);

    typedef struct {
        string       tag;
        logic [31:0] tot, ls, bs, tk, ut;
        logic [15:0] mask;
    } exp_t;

    exp_t exp_q[$];
    int vectors = 0, fails = 0;

    logic [15:0] m_act = '0, m_pend = '0;
    logic [31:0] m_max = '0, m_tot = '0, m_ls = '0, m_bs = '0, m_tk = '0, m_ut = '0;

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push(string tag);
        exp_t e;
        e.tag = tag; e.tot = m_tot; e.ls = m_ls; e.bs = m_bs;
        e.tk = m_tk; e.ut = m_ut; e.mask = m_act;
        exp_q.push_back(e);
    endtask

    task automatic issue(string tag, bit first, bit last, logic [4:0] sa, logic [4:0] sb,
                         bit ld, logic [3:0] dst, bit br, bit tk, logic [7:0] base);
        logic [31:0] ls, bs, tot;
        @(negedge clk);
        in_valid = 1'b1; in_first = first; in_last = last; in_src_a = sa; in_src_b = sb;
        in_is_load = ld; in_dst = dst; in_is_branch = br; in_taken = tk; in_base = base;
        if (first) begin m_pend = '0; m_max = '0; end
        ls = 0;
        if (sa < 16 && m_act[sa[3:0]]) ls += 2;
        if (sb < 16 && m_act[sb[3:0]]) ls += 2;
        bs = (br && tk) ? 32'd2 : 32'd0;
        tot = 32'(base) + ls + bs;
        if (last) m_tot += (tot > m_max) ? tot : m_max;
        else m_max = tot;
        m_ls += ls; m_bs += bs;
        if (br) begin if (tk) m_tk++; else m_ut++; end
        if (ld) m_pend[dst] = 1'b1;
        m_act = m_pend;
        push(tag);
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b1; in_last = 1'b1; in_is_load = 1'b1;
        in_is_branch = 1'b1; in_taken = 1'b1; in_base = 8'd9; in_src_a = 5'd2;
        push(tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                cmp(e.tag, "total_cycles", total_cycles, e.tot);
                cmp(e.tag, "load_stall_cycles", load_stall_cycles, e.ls);
                cmp(e.tag, "branch_stall_cycles", branch_stall_cycles, e.bs);
                cmp(e.tag, "taken_count", taken_count, e.tk);
                cmp(e.tag, "untaken_count", untaken_count, e.ut);
                cmp(e.tag, "load_mask", 32'(load_mask), 32'(e.mask));
            end
        end
    end

    initial begin : watchdog
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #5;
        cmp("R1", "total_cycles reset", total_cycles, 0);
        cmp("R1", "load_mask reset", 32'(load_mask), 0);
        cmp("R1", "taken_count reset", taken_count, 0);
        @(negedge clk);
        rst_n = 1'b1;
        issue("R6", 1, 1, 5'h10, 5'h10, 0, 0, 0, 0, 8'd1);
        issue("R3", 1, 1, 5'h10, 5'h10, 1, 3, 0, 0, 8'd1);
        issue("R2", 1, 1, 5'd3, 5'h10, 0, 0, 0, 0, 8'd1);
        issue("R3", 1, 1, 5'd3, 5'h10, 0, 0, 0, 0, 8'd1);
        issue("R3", 1, 1, 5'h10, 5'h10, 1, 3, 0, 0, 8'd1);
        issue("R2", 1, 1, 5'h13, 5'h13, 0, 0, 0, 0, 8'd1);
        issue("R3", 1, 1, 5'h10, 5'h10, 1, 5, 0, 0, 8'd2);
        issue("R2", 1, 1, 5'd5, 5'd5, 0, 0, 0, 0, 8'd1);
        issue("R4", 1, 1, 5'h10, 5'h10, 0, 0, 1, 1, 8'd1);
        issue("R5", 1, 1, 5'h10, 5'h10, 0, 0, 1, 0, 8'd1);
        issue("R7", 1, 0, 5'h10, 5'h10, 0, 0, 0, 0, 8'd5);
        issue("R8", 0, 1, 5'h10, 5'h10, 0, 0, 1, 1, 8'd1);
        idle("R9"); idle("R9"); idle("R9");
        issue("R7", 1, 0, 5'h10, 5'h10, 1, 2, 0, 0, 8'd1);
        issue("R8", 0, 1, 5'd2, 5'h10, 0, 0, 0, 0, 8'd1);
        issue("R3", 1, 1, 5'h10, 5'd2, 0, 0, 0, 0, 8'd3);
        issue("R7", 1, 0, 5'h10, 5'h10, 0, 0, 0, 0, 8'd2);
        issue("R7", 0, 1, 5'h10, 5'h10, 1, 9, 0, 0, 8'd4);
        issue("R3", 1, 1, 5'd9, 5'h10, 0, 0, 0, 0, 8'd1);
        idle("R9");
        while (exp_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule